// File: doc/BRIEF.md
# Key-locked system control register bank

This block is a bank of 32-bit system control registers behind a plain word bus with address, write strobe, write data, read strobe and read data. The bus covers a 4 KiB byte window, and each register sits at an offset that is four times its index. Only aligned 32-bit accesses are legal. A protection key register at offset 0x000 holds a lock. While the bank is locked, the configuration window from 0x004 to 0x100 refuses writes. A few registers are read-only status, one register is write-only, and the revision and two strap words are captured from input pins while reset is held.

The lock is a two-state machine. In `ST_LOCKED`, a write of the key value to offset 0x000 takes the transition `KEY_MATCH` into `ST_OPEN`. In `ST_OPEN`, a write of any other value to 0x000 takes `KEY_MISS` back to `ST_LOCKED`. A key write in the state it would lead to leaves the state unchanged. While reset is held, the machine enters `ST_OPEN` if `start_open` is high and `ST_LOCKED` otherwise. Reads of 0x000 report the state as 1 or 0 and never return the value that was written.

The reset values of the bank come from one of two tables. The revision input picks the table. A revision outside the four supported values uses the first table and raises `cfg_err`. Every access that the bank refuses, and every access it does not support, raises `bus_err` for one cycle. The error appears in the same cycle that the read data returns.

Top module: `sysctl_keyed_bank`

## Requirements
- R1: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and it holds until the next read. A read of 0x000 returns 32'h1 in `ST_OPEN` and 32'h0 in `ST_LOCKED`.
- R2: A write of `KEY_VALUE` to 0x000 makes the state `ST_OPEN`. A write of any other value to 0x000 makes the state `ST_LOCKED`. Key writes are never refused.
- R3: In `ST_LOCKED`, a write to any offset from 0x004 to 0x100 is dropped and `bus_err` pulses. In `ST_OPEN`, the same writes are stored, including a write to 0x100.
- R4: A write to an offset from 0x104 up to 0x1A4 is stored in either lock state.
- R5: Writes are dropped and `bus_err` pulses at the read-only offsets 0x14, 0x50 through 0x6C, 0x78, 0x7C, 0xE0 and 0xE4. This holds even in `ST_OPEN`.
- R6: A read of 0xC0 returns the stored value and pulses `bus_err`. A write to 0xC0 is stored like any other write.
- R7: A read at an offset of 0x1A8 or above, or at an address whose low two bits are not zero, returns 0 and pulses `bus_err`. A write at such an address is dropped and pulses `bus_err`.
- R8: While reset is held, 0x7C captures `rev_id`, 0x70 captures `strap_a_in`, 0xD0 captures `strap_b_in`, and the lock state follows `start_open`.
- R9: When `rev_id` is `REV_B0` or `REV_B1`, the reset values are 0x24 = 93000400, 0x88 = 03000000, 0x8C = 00000000 and 0x9C = 023FFFF3. For any other revision they are 00000291, 01000000, 000000FF and 003FFFF3. Both tables give 0x04 = FFCFFEDC and 0x1A4 = 00002402.
- R10: `cfg_err` is high exactly when `rev_id` is none of `REV_A0`, `REV_A1`, `REV_B0` or `REV_B1`. An unsupported revision loads the first table.
- R11: Offsets with no listed reset value reset to 0. Allowed writes to them are stored and read back unchanged.
- R12: `bus_err` stays low after a legal access and after an idle cycle. It is high for exactly one cycle per offending access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the tables, straps and revision |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle pulse for a refused or illegal access |
| rev_id | input | 32 | Silicon revision; selects the reset table |
| strap_a_in | input | 32 | Strap word captured into 0x70 at reset |
| strap_b_in | input | 32 | Strap word captured into 0xD0 at reset |
| start_open | input | 1 | Lock state taken during reset (1 = open) |
| cfg_err | output | 1 | High when `rev_id` is not a supported revision |

## Verification
The assertions assume that `rev_id` and both strap words have settled before reset is released and stay constant afterwards. They also assume that every bus input has a known value at each clock edge after reset. The bench changes the revision, the straps and `start_open` only while `rst_n` is low. Across three resets it uses three revisions: one from each table and one unsupported. It never raises `bus_rd` and `bus_wr` in the same cycle, and it releases both strobes between accesses, so each expected result belongs to exactly one access.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int unsigned SCB_DW = 32;

    // Register indices whose behaviour other logic depends on
    localparam int unsigned IDX_KEY     = 0;
    localparam int unsigned IDX_STRAP_A = 28;   // 0x70
    localparam int unsigned IDX_REV     = 31;   // 0x7C
    localparam int unsigned IDX_WO      = 48;   // 0xC0
    localparam int unsigned IDX_STRAP_B = 52;   // 0xD0

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_t;

    function automatic logic is_ro_idx(input int unsigned idx);
        return (idx == 5) || (idx >= 20 && idx <= 27) || (idx == 30) ||
               (idx == 31) || (idx == 56) || (idx == 57);
    endfunction

    // Reset value for a word index; tbl_b selects the second table
    function automatic logic [SCB_DW-1:0] reset_word(input int unsigned idx,
                                                     input logic tbl_b);
        logic [SCB_DW-1:0] v;
        v = '0;
        case (idx)
            // entries that differ between the tables
            9:   v = tbl_b ? 32'h9300_0400 : 32'h0000_0291;
            34:  v = tbl_b ? 32'h0300_0000 : 32'h0100_0000;
            35:  v = tbl_b ? 32'h0000_0000 : 32'h0000_00FF;
            39:  v = tbl_b ? 32'h023F_FFF3 : 32'h003F_FFF3;
            // clock and reset control group
            1:   v = 32'hFFCF_FEDC;
            2:   v = 32'hF3F4_0000;
            3:   v = 32'h19FC_3E8B;
            7:   v = 32'h0002_6108;
            8:   v = 32'h0003_0291;
            15:  v = 32'h0000_0001;
            // misc and bus control group
            11:  v = 32'h0000_0010;
            19:  v = 32'h0000_0023;
            12,
            13:  v = 32'h2000_1A03;
            14:  v = 32'h0400_0030;
            16:  v = 32'h0000_00C0;
            29:  v = 32'h0000_000E;
            // pin function group
            33:  v = 32'h0000_F000;
            36:  v = 32'h0000_A000;
            41:  v = 32'hFFFF_0000;
            42:  v = 32'h000F_FFFF;
            // counters and secondary core windows
            56,
            57:  v = 32'h0000_00FF;
            65:  v = 32'h8000_0000;
            68:  v = 32'h1E60_0000;
            69:  v = 32'hC000_0000;
            88:  v = 32'h0000_1903;
            96:  v = 32'h0000_007B;
            105: v = 32'h0000_2402;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/scb_decode.sv
module scb_decode #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned NUM_REGS     = 106,
    parameter int unsigned GATE_END_OFS = 32'h104,
    localparam int unsigned IDX_W       = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              aligned,
    output logic              in_range,
    output logic              is_key,
    output logic              is_ro,
    output logic              is_wo,
    output logic              in_gate
);
    import scb_pkg::*;

    localparam int unsigned GATE_END_IDX = GATE_END_OFS >> 2;

    int unsigned idx_u;

    always_comb begin
        idx      = addr[ADDR_W-1:2];
        idx_u    = 32'(idx);
        aligned  = (addr[1:0] == 2'b00);
        in_range = (idx_u < NUM_REGS);
        is_key   = (idx_u == IDX_KEY);
        is_wo    = (idx_u == IDX_WO);
        is_ro    = is_ro_idx(idx_u);
        in_gate  = (idx_u != IDX_KEY) && (idx_u < GATE_END_IDX);
    end

endmodule

// File: rtl/scb_lock_fsm.sv
module scb_lock_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic start_open,
    input  logic key_wr,
    input  logic key_match,
    output logic unlocked
);
    import scb_pkg::*;

    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= start_open ? ST_OPEN : ST_LOCKED;
        else        state_q <= state_d;
    end

    // transitions KEY_MATCH and KEY_MISS
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (key_wr && key_match)  state_d = ST_OPEN;
            ST_OPEN:   if (key_wr && !key_match) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb unlocked = (state_q == ST_OPEN);

    assert_key_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_match) |=> unlocked);
    assert_key_shut_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_match) |=> !unlocked);

endmodule

// File: rtl/scb_regfile.sv
module scb_regfile #(
    parameter int unsigned NUM_REGS = 106,
    parameter int unsigned IDX_W    = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tbl_b,
    input  logic [scb_pkg::SCB_DW-1:0] rev,
    input  logic [scb_pkg::SCB_DW-1:0] strap_a,
    input  logic [scb_pkg::SCB_DW-1:0] strap_b,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  logic [scb_pkg::SCB_DW-1:0] wdata,
    input  logic [IDX_W-1:0]          ridx,
    output logic [scb_pkg::SCB_DW-1:0] rdata
);
    import scb_pkg::*;

    logic [NUM_REGS-1:0][SCB_DW-1:0] init_v;
    logic [NUM_REGS-1:0][SCB_DW-1:0] mem;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_init
        if (i == IDX_REV) begin : g_rev
            assign init_v[i] = rev;
        end else if (i == IDX_STRAP_A) begin : g_sa
            assign init_v[i] = strap_a;
        end else if (i == IDX_STRAP_B) begin : g_sb
            assign init_v[i] = strap_b;
        end else begin : g_tbl
            assign init_v[i] = reset_word(i, tbl_b);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= init_v;
        end else if (we) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (widx == IDX_W'(i)) mem[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ridx == IDX_W'(i)) rdata = mem[i];
        end
    end

    // revision word never changes between resets
    assert_rev_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mem[IDX_REV]));

endmodule

// File: rtl/sysctl_keyed_bank.sv
module sysctl_keyed_bank #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned NUM_REGS     = 106,
    parameter int unsigned GATE_END_OFS = 32'h104,
    parameter logic [31:0] KEY_VALUE    = 32'hA5C3_0F96,
    parameter logic [31:0] REV_A0       = 32'h0100_0001,
    parameter logic [31:0] REV_A1       = 32'h0100_0002,
    parameter logic [31:0] REV_B0       = 32'h0200_0001,
    parameter logic [31:0] REV_B1       = 32'h0200_0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [31:0]       rev_id,
    input  logic [31:0]       strap_a_in,
    input  logic [31:0]       strap_b_in,
    input  logic              start_open,
    output logic              cfg_err
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic aligned, in_range, is_key, is_ro, is_wo, in_gate;
    logic unlocked, tbl_b, acc_bad;
    logic key_wr, wr_block, rd_flag, wr_commit, err_d;
    logic [31:0] rf_rdata, rdata_d;

    scb_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .GATE_END_OFS(GATE_END_OFS)
    ) u_dec (
        .addr(bus_addr), .idx(idx), .aligned(aligned), .in_range(in_range),
        .is_key(is_key), .is_ro(is_ro), .is_wo(is_wo), .in_gate(in_gate)
    );

    always_comb begin
        tbl_b   = (rev_id == REV_B0) || (rev_id == REV_B1);
        cfg_err = !(tbl_b || (rev_id == REV_A0) || (rev_id == REV_A1));

        acc_bad   = !aligned || !in_range;
        key_wr    = bus_wr && !acc_bad && is_key;
        wr_block  = bus_wr && (acc_bad || (!unlocked && in_gate) || is_ro);
        rd_flag   = bus_rd && (acc_bad || is_wo);
        wr_commit = bus_wr && !wr_block && !is_key;
        err_d     = wr_block || rd_flag;

        if (acc_bad)     rdata_d = '0;
        else if (is_key) rdata_d = {31'b0, unlocked};
        else             rdata_d = rf_rdata;
    end

    scb_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .start_open(start_open),
        .key_wr(key_wr), .key_match(bus_wdata == KEY_VALUE),
        .unlocked(unlocked)
    );

    scb_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .tbl_b(tbl_b), .rev(rev_id),
        .strap_a(strap_a_in), .strap_b(strap_b_in),
        .we(wr_commit), .widx(idx), .wdata(bus_wdata),
        .ridx(idx), .rdata(rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= err_d;
            if (bus_rd) bus_rdata <= rdata_d;
        end
    end

    assert_key_view_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && aligned && is_key) |=> (bus_rdata[31:1] == 31'b0));
    assert_gate_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !unlocked && in_gate) |=> bus_err);
    assert_oor_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_range) |=> (bus_rdata == 32'b0 && bus_err));
    assert_err_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !bus_rd) |=> !bus_err);
    assert_wo_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && aligned && is_wo) |=> bus_err);

endmodule

// File: tb/sysctl_keyed_bank_test.sv
module sysctl_keyed_bank_test;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] KEY  = 32'hA5C3_0F96;
    localparam logic [31:0] RA0  = 32'h0100_0001;
    localparam logic [31:0] RB1  = 32'h0200_0002;
    localparam logic [31:0] RBAD = 32'hDEAD_0000;

    logic clk = 0, rst_n = 0;
    logic [11:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0, start_open = 0;
    logic [31:0] bus_wdata = '0, rev_id = RA0, strap_a_in = '0, strap_b_in = '0;
    logic [31:0] bus_rdata;
    logic bus_err, cfg_err;

    int vectors = 0, fails = 0;

    logic        q_chk[$];
    logic [31:0] q_dat[$];
    logic        q_err[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_keyed_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .rev_id(rev_id), .strap_a_in(strap_a_in),
        .strap_b_in(strap_b_in), .start_open(start_open), .cfg_err(cfg_err)
    );

    // monitor: result of an access shows one edge after it is driven
    always @(posedge clk) begin
        #2;
        if (q_err.size() > 0) begin
            logic c; logic [31:0] d; logic e; string t;
            c = q_chk.pop_front(); d = q_dat.pop_front();
            e = q_err.pop_front(); t = q_tag.pop_front();
            vectors++;
            if ((c && bus_rdata !== d) || bus_err !== e) begin
                fails++;
                $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                         t, bus_rdata, bus_err, d, e);
            end
        end
    end

    task automatic do_rd(input logic [11:0] a, input logic [31:0] d,
                         input logic e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1; bus_wr = 0;
        q_chk.push_back(1); q_dat.push_back(d); q_err.push_back(e); q_tag.push_back(t);
        @(posedge clk); #1 bus_rd = 0;
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d,
                         input logic e, input string t);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        q_chk.push_back(0); q_dat.push_back('0); q_err.push_back(e); q_tag.push_back(t);
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic do_reset(input logic [31:0] rv, input logic so);
        @(negedge clk);
        rst_n = 0; rev_id = rv; start_open = so;
        strap_a_in = 32'h1234_5678 ^ rv; strap_b_in = 32'hCAFE_F00D ^ rv;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic chk_cfg(input logic e, input string t);
        vectors++;
        if (cfg_err !== e) begin
            fails++;
            $display("FAIL %s: cfg_err=%b expected %b", t, cfg_err, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // ---- first table, starts locked
        do_reset(RA0, 0);
        chk_cfg(0, "R10 supported rev A0");
        do_rd(12'h000, 32'h0, 0, "R8 key reads locked after reset");
        do_rd(12'h07C, RA0, 0, "R8 revision captured");
        do_rd(12'h070, 32'h1234_5678 ^ RA0, 0, "R8 strap A captured");
        do_rd(12'h0D0, 32'hCAFE_F00D ^ RA0, 0, "R8 strap B captured");
        do_rd(12'h024, 32'h0000_0291, 0, "R9 table A 0x24");
        do_rd(12'h088, 32'h0100_0000, 0, "R9 table A 0x88");
        do_rd(12'h08C, 32'h0000_00FF, 0, "R9 table A 0x8C");
        do_rd(12'h09C, 32'h003F_FFF3, 0, "R9 table A 0x9C");
        do_rd(12'h004, 32'hFFCF_FEDC, 0, "R9 shared 0x04");
        do_rd(12'h1A4, 32'h0000_2402, 0, "R9 shared 0x1A4");
        do_rd(12'h010, 32'h0, 0, "R11 unlisted resets to zero");
        // lock gate
        do_wr(12'h010, 32'hDEAD_0001, 1, "R3 locked write flagged");
        do_rd(12'h010, 32'h0, 0, "R3 locked write dropped");
        do_wr(12'h100, 32'h0000_0099, 1, "R3 locked write at 0x100 flagged");
        do_wr(12'h104, 32'h1111_2222, 0, "R4 write above gate while locked");
        do_rd(12'h104, 32'h1111_2222, 0, "R4 value stored while locked");
        // key
        do_wr(12'h000, 32'h0000_0001, 0, "R2 wrong key accepted silently");
        do_rd(12'h000, 32'h0, 0, "R2 wrong key keeps locked");
        do_wr(12'h000, KEY, 0, "R2 key write");
        do_rd(12'h000, 32'h1, 0, "R1 key reads 1 not the value");
        do_wr(12'h010, 32'hDEAD_BEEF, 0, "R11 open write legal");
        do_rd(12'h010, 32'hDEAD_BEEF, 0, "R11 open write stored");
        do_wr(12'h100, 32'h0000_0055, 0, "R3 open write 0x100");
        do_rd(12'h100, 32'h0000_0055, 0, "R3 open write 0x100 stored");
        // read-only
        do_wr(12'h014, 32'hFFFF_FFFF, 1, "R5 write 0x14 flagged");
        do_rd(12'h014, 32'h0, 0, "R5 0x14 unchanged");
        do_wr(12'h07C, 32'h0, 1, "R5 write revision flagged");
        do_rd(12'h07C, RA0, 0, "R5 revision unchanged");
        do_wr(12'h050, 32'h5A5A_5A5A, 1, "R5 write 0x50 flagged");
        do_wr(12'h06C, 32'h5A5A_5A5A, 1, "R5 write 0x6C flagged");
        do_rd(12'h06C, 32'h0, 0, "R5 0x6C unchanged");
        do_wr(12'h0E4, 32'h0, 1, "R5 write 0xE4 flagged");
        do_rd(12'h0E4, 32'h0000_00FF, 0, "R5 0xE4 unchanged");
        // write-only
        do_wr(12'h0C0, 32'h0000_ABCD, 0, "R6 write 0xC0 legal");
        do_rd(12'h0C0, 32'h0000_ABCD, 1, "R6 read 0xC0 value and flag");
        // out of range and unaligned
        do_rd(12'h1A8, 32'h0, 1, "R7 read past array");
        do_rd(12'hFFC, 32'h0, 1, "R7 read window end");
        do_wr(12'h1A8, 32'h7777_7777, 1, "R7 write past array");
        do_rd(12'h106, 32'h0, 1, "R7 unaligned read");
        do_wr(12'h012, 32'h0BAD_0BAD, 1, "R7 unaligned write flagged");
        do_rd(12'h010, 32'hDEAD_BEEF, 0, "R7 unaligned write dropped");
        // relock
        do_wr(12'h000, 32'h1234_0000, 0, "R2 relock");
        do_wr(12'h100, 32'h0000_0077, 1, "R3 relocked write flagged");
        do_rd(12'h100, 32'h0000_0055, 0, "R3 relocked write dropped");
        do_rd(12'h104, 32'h1111_2222, 0, "R12 legal read no flag");
        // ---- second table, starts open
        do_reset(RB1, 1);
        chk_cfg(0, "R10 supported rev B1");
        do_rd(12'h000, 32'h1, 0, "R8 key reads open after reset");
        do_rd(12'h024, 32'h9300_0400, 0, "R9 table B 0x24");
        do_rd(12'h088, 32'h0300_0000, 0, "R9 table B 0x88");
        do_rd(12'h08C, 32'h0000_0000, 0, "R9 table B 0x8C");
        do_rd(12'h09C, 32'h023F_FFF3, 0, "R9 table B 0x9C");
        do_rd(12'h004, 32'hFFCF_FEDC, 0, "R9 table B shared 0x04");
        do_rd(12'h010, 32'h0, 0, "R11 reset clears stored word");
        do_wr(12'h020, 32'h0000_1234, 0, "R3 open from reset write");
        do_rd(12'h020, 32'h0000_1234, 0, "R3 open from reset stored");
        // ---- unsupported revision
        do_reset(RBAD, 0);
        chk_cfg(1, "R10 unsupported rev flagged");
        do_rd(12'h024, 32'h0000_0291, 0, "R10 unsupported uses table A");
        do_rd(12'h07C, RBAD, 0, "R8 unsupported rev captured");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule